// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

This block collects event pulses from a set of ports and from a group of chip-wide sources, and folds them into one active-low interrupt line. Every source bit is caught on its rising edge in a sticky latched bit. Software clears a latched bit by writing a one to it.

Each latched bit has an enable. The enabled latched bits of one port are ORed into that port's summary bit. The port summary bits have their own enables, and the enabled ones merge into a single global summary. That global summary reaches the pin only when a global summary enable is set. The chip-wide latched bits have their own enables and drive the pin directly, without passing through the port path.

Software reaches the block through a simple register port. A write takes effect at the clock edge while `bus_sel` and `bus_we` are high. Read data follows `bus_addr` combinationally.

The register map:

| Address | Contents | Access |
|---|---|---|
| 0 | chip-wide latched bits | write one to clear |
| 1 | chip-wide latched enables | read/write |
| 2 | port summary bits, bit p for port p | read-only |
| 3 | port summary enables | read/write |
| 4 | bit 0: global summary enable; bit 1: global summary status | bit 0 read/write, bit 1 read-only |
| 8+2p | latched bits of port p | write one to clear |
| 9+2p | latched enables of port p | read/write |

Top module: `irq_tree`

## Requirements
- R1: After reset, every latched bit, every enable and every readable register is zero, and `irq_n` is high.
- R2: A latched bit is set on the clock edge where its event input is high and was low at the previous edge. An event held high sets the bit only once, so after a clear the bit stays clear while the event stays high.
- R3: A write of data D to a latched register (address 0 or 8+2p) clears exactly the bits that are one in D. Bits written as zero keep their value.
- R4: When a new rising event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Bit p at address 2 equals the OR of the latched bits of port p ANDed with that port's enables (address 9+2p).
- R6: Bit 1 at address 4 is the OR of the port summary bits ANDed with the summary enables (address 3). It drives `irq_n` low only while bit 0 at address 4 is one.
- R7: A chip-wide latched bit (address 0) whose enable (address 1) is set drives `irq_n` low, whatever the summary enables hold.
- R8: `irq_n` is low exactly while an enabled chip-wide latched bit exists or the gated global summary is active. It returns high on its own once every contributing bit is cleared or masked.
- R9: Writes to address 2 have no effect, and read-only bit 1 at address 4 cannot be written.
- R10: Unmapped addresses (5 to 7, and above the last port register) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_evt | input | GLB_BITS | Chip-wide event inputs |
| port_evt | input | NUM_PORTS*PORT_BITS | Port events, port p at bits p*PORT_BITS upward |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq_n | output | 1 | Active-low interrupt |

## Verification
For every port, the bench tries all 256 pairs of latched pattern and enable pattern and checks the port summary bit against the masked OR. This catches a missing mask, a wrong bit order and leakage between ports. All 256 pairs are also run on the chip-wide latched bits, and `irq_n` is checked against the masked OR, which shows that the direct path ignores the summary enables. For the port path, the bench tries every combination of summary enables with both settings of the global enable, which separates the two gating levels. Directed patterns then cover:
- a held-high event, to separate edge capture from level capture;
- a partial clear mask;
- an event arriving in the same cycle as its clear;
- writes to read-only locations;
- reads of unmapped addresses.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
    // Register map
    localparam int unsigned A_GLAT      = 0;  // chip-wide latched, write one to clear
    localparam int unsigned A_GEN       = 1;  // chip-wide enables
    localparam int unsigned A_PSTAT     = 2;  // port summary bits, read-only
    localparam int unsigned A_PEN       = 3;  // port summary enables
    localparam int unsigned A_TOP       = 4;  // bit0 global enable, bit1 global status
    localparam int unsigned A_PORT_BASE = 8;  // port p latched at base+2p, enables at base+2p+1
    localparam int unsigned PORT_STRIDE = 2;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] lat
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] lat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [W-1:0] rise;
        logic [W-1:0] kill;
        rise      = evt & ~st_q.prev;
        kill      = clr_we ? clr_mask : '0;
        st_d.prev = evt;
        // a new edge takes priority over a clear in the same cycle
        st_d.lat  = (st_q.lat & ~kill) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat = st_q.lat;
endmodule

// File: rtl/irq_port_node.sv
module irq_port_node #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         lat_clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] lat,
    output logic [W-1:0] en,
    output logic         summary
);
    typedef struct packed {
        logic [W-1:0] en;
    } st_t;

    st_t st_d, st_q;

    irq_edge_latch #(.W(W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_we   (lat_clr_we),
        .clr_mask (wdata),
        .lat      (lat)
    );

    always_comb begin
        st_d = st_q;
        if (en_we) st_d.en = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en      = st_q.en;
    assign summary = |(lat & st_q.en);
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned GLB_BITS  = 4
) (
    input  logic [GLB_BITS-1:0]  glb_lat,
    input  logic [GLB_BITS-1:0]  glb_en,
    input  logic [NUM_PORTS-1:0] psum,
    input  logic [NUM_PORTS-1:0] psum_en,
    input  logic                 gsum_en,
    output logic                 gsum_status,
    output logic                 irq_n
);
    logic glb_hit;

    always_comb begin
        glb_hit     = |(glb_lat & glb_en);
        gsum_status = |(psum & psum_en);
        irq_n       = ~(glb_hit | (gsum_en & gsum_status));
    end
endmodule

// File: rtl/irq_tree.sv
module irq_tree
    import irq_tree_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_BITS = 4,
    parameter int unsigned GLB_BITS  = 4,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [GLB_BITS-1:0]            glb_evt,
    input  logic [NUM_PORTS*PORT_BITS-1:0] port_evt,
    input  logic                           bus_sel,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic                           irq_n
);
    localparam int unsigned LAST_ADDR = A_PORT_BASE + PORT_STRIDE * NUM_PORTS - 1;

    typedef struct packed {
        logic [GLB_BITS-1:0]  glb_en;
        logic [NUM_PORTS-1:0] psum_en;
        logic                 gsum_en;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 wr;
    logic [GLB_BITS-1:0]  glb_lat;
    logic [NUM_PORTS-1:0] psum;
    logic                 gsum_status;
    logic [PORT_BITS-1:0] plat [NUM_PORTS];
    logic [PORT_BITS-1:0] pen  [NUM_PORTS];
    logic                 unused_wdata_bits;

    assign wr                = bus_sel & bus_we;
    assign unused_wdata_bits = ^bus_wdata;

    irq_edge_latch #(.W(GLB_BITS)) u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (glb_evt),
        .clr_we   (wr && (bus_addr == ADDR_W'(A_GLAT))),
        .clr_mask (bus_wdata[GLB_BITS-1:0]),
        .lat      (glb_lat)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        irq_port_node #(.W(PORT_BITS)) u_node (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt        (port_evt[p*PORT_BITS +: PORT_BITS]),
            .lat_clr_we (wr && (bus_addr == ADDR_W'(A_PORT_BASE + PORT_STRIDE*p))),
            .en_we      (wr && (bus_addr == ADDR_W'(A_PORT_BASE + PORT_STRIDE*p + 1))),
            .wdata      (bus_wdata[PORT_BITS-1:0]),
            .lat        (plat[p]),
            .en         (pen[p]),
            .summary    (psum[p])
        );
    end

    irq_out_stage #(.NUM_PORTS(NUM_PORTS), .GLB_BITS(GLB_BITS)) u_out (
        .glb_lat     (glb_lat),
        .glb_en      (ctl_q.glb_en),
        .psum        (psum),
        .psum_en     (ctl_q.psum_en),
        .gsum_en     (ctl_q.gsum_en),
        .gsum_status (gsum_status),
        .irq_n       (irq_n)
    );

    // control register next state
    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            if (bus_addr == ADDR_W'(A_GEN)) ctl_d.glb_en  = bus_wdata[GLB_BITS-1:0];
            if (bus_addr == ADDR_W'(A_PEN)) ctl_d.psum_en = bus_wdata[NUM_PORTS-1:0];
            if (bus_addr == ADDR_W'(A_TOP)) ctl_d.gsum_en = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_GLAT))  bus_rdata = DATA_W'(glb_lat);
        if (bus_addr == ADDR_W'(A_GEN))   bus_rdata = DATA_W'(ctl_q.glb_en);
        if (bus_addr == ADDR_W'(A_PSTAT)) bus_rdata = DATA_W'(psum);
        if (bus_addr == ADDR_W'(A_PEN))   bus_rdata = DATA_W'(ctl_q.psum_en);
        if (bus_addr == ADDR_W'(A_TOP))   bus_rdata = DATA_W'({gsum_status, ctl_q.gsum_en});
        if (bus_addr <= ADDR_W'(LAST_ADDR)) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_addr == ADDR_W'(A_PORT_BASE + PORT_STRIDE*p))     bus_rdata = DATA_W'(plat[p]);
                if (bus_addr == ADDR_W'(A_PORT_BASE + PORT_STRIDE*p + 1)) bus_rdata = DATA_W'(pen[p]);
            end
        end
    end
endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk
    import irq_tree_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned GLB_BITS  = 4,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [GLB_BITS-1:0]  glb_evt,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 irq_n,
    input logic [GLB_BITS-1:0]  glb_lat,
    input logic [GLB_BITS-1:0]  glb_en,
    input logic [NUM_PORTS-1:0] psum,
    input logic                 gsum_en
);
    logic glb_clr;
    assign glb_clr = bus_sel && bus_we && (bus_addr == ADDR_W'(A_GLAT));

    always @(negedge clk) begin
        if (!rst_n) assert_reset_quiet_R1: assert (irq_n === 1'b1);
    end

    for (genvar i = 0; i < GLB_BITS; i++) begin : g_bit
        // set bit stays set unless a one is written to it
        assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (glb_lat[i] && !(glb_clr && bus_wdata[i])) |=> glb_lat[i]);
        // a rising event always leaves the bit set, even against a clear
        assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(glb_evt[i]) |=> glb_lat[i]);
    end

    assert_direct_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(glb_lat & glb_en)) |-> !irq_n);

    assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((|(glb_lat & glb_en)) || (gsum_en && (|psum))));

    assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gsum_en && !(|(glb_lat & glb_en))) |-> irq_n);
endmodule

bind irq_tree irq_tree_chk #(
    .NUM_PORTS (NUM_PORTS),
    .GLB_BITS  (GLB_BITS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_evt   (glb_evt),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_n     (irq_n),
    .glb_lat   (glb_lat),
    .glb_en    (ctl_q.glb_en),
    .psum      (psum),
    .gsum_en   (ctl_q.gsum_en)
);

// File: tb/irq_tree_test.sv
`timescale 1ns/1ps
module irq_tree_test;
    localparam int NP = 4;
    localparam int PB = 4;
    localparam int GB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [GB-1:0] glb_evt = '0;
    logic [NP*PB-1:0] port_evt = '0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          irq_n;

    int n_checks = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    irq_tree uut (
        .clk(clk), .rst_n(rst_n), .glb_evt(glb_evt), .port_evt(port_evt),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 5'(a);
        #1 d = bus_rdata;
    endtask

    task automatic pulse_port(input int p, input logic [PB-1:0] m);
        @(negedge clk);
        port_evt[p*PB +: PB] = m;
        @(negedge clk);
        port_evt = '0;
    endtask

    task automatic pulse_glb(input logic [GB-1:0] m);
        @(negedge clk);
        glb_evt = m;
        @(negedge clk);
        glb_evt = '0;
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] d2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq_n in reset", irq_n, 1);
        rst_n = 1'b1;
        chk("R1 irq_n after reset", irq_n, 1);
        for (int a = 0; a < 16; a++) begin
            rd(a, d);
            chk("R1 register zero after reset", d, 0);
        end

        // R5 / R2: all latched x enable patterns on every port
        for (int p = 0; p < NP; p++) begin
            for (int l = 0; l < 16; l++) begin
                for (int e = 0; e < 16; e++) begin
                    wr(8 + 2*p, 8'hFF);
                    pulse_port(p, PB'(l));
                    wr(9 + 2*p, 8'(e));
                    rd(8 + 2*p, d);
                    chk("R2 port latched pattern", d, l);
                    rd(2, d);
                    chk("R5 port summary bit", d[p], |(l & e));
                    chk("R6 no irq with summary enables off", irq_n, 1);
                end
            end
            wr(8 + 2*p, 8'hFF);
            wr(9 + 2*p, 8'h00);
            rd(2, d);
            chk("R8 summary clears itself", d, 0);
        end

        // R6: two gating levels on the port path
        pulse_port(0, 4'h1);
        wr(9, 8'h01);
        for (int pe = 0; pe < 16; pe++) begin
            for (int ge = 0; ge < 2; ge++) begin
                wr(3, 8'(pe));
                wr(4, 8'(ge));
                rd(4, d);
                chk("R6 global status bit", d[1], pe[0]);
                chk("R6 global enable bit", d[0], ge[0]);
                chk("R6 irq_n through summary", irq_n, !(ge[0] && pe[0]));
            end
        end
        // R9: read-only locations
        rd(2, d);
        wr(2, 8'h00);
        rd(2, d2);
        chk("R9 write to summary ignored", d2, d);
        wr(4, 8'h00);
        rd(4, d);
        chk("R9 status bit not writable", d, 8'h02);
        wr(8, 8'h0F); wr(9, 8'h00); wr(3, 8'h00);
        chk("R8 irq high after port path cleared", irq_n, 1);

        // R7: chip-wide latched x enable, summary enables all off
        for (int l = 0; l < 16; l++) begin
            for (int e = 0; e < 16; e++) begin
                wr(0, 8'hFF);
                pulse_glb(GB'(l));
                wr(1, 8'(e));
                rd(0, d);
                chk("R2 global latched pattern", d, l);
                chk("R7 irq_n from direct path", irq_n, !(|(l & e)));
            end
        end

        // R3: partial clear
        wr(0, 8'hFF);
        pulse_glb(4'hF);
        wr(0, 8'h05);
        rd(0, d);
        chk("R3 partial clear", d, 8'h0A);

        // R8: mask and clear release the line
        wr(1, 8'h0F);
        chk("R8 irq low while enabled", irq_n, 0);
        wr(1, 8'h00);
        chk("R8 irq high when masked", irq_n, 1);
        wr(1, 8'h0F);
        wr(0, 8'h0F);
        chk("R8 irq high when cleared", irq_n, 1);

        // R2: level held high does not re-latch
        @(negedge clk); glb_evt = 4'h1;
        @(negedge clk);
        wr(0, 8'h01);
        repeat (3) @(negedge clk);
        rd(0, d);
        chk("R2 held event no relatch", d, 0);
        glb_evt = '0;

        // R4: new edge and clear in the same cycle
        pulse_glb(4'h2);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'd0; bus_wdata = 8'h02;
        glb_evt = 4'h2;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; glb_evt = '0;
        rd(0, d);
        chk("R4 event wins over clear", d, 8'h02);
        wr(0, 8'h0F); wr(1, 8'h00);

        // R10: unmapped addresses
        for (int a = 5; a < 8; a++) begin
            rd(a, d);
            chk("R10 unmapped reads zero", d, 0);
        end
        for (int a = 16; a < 32; a++) begin
            rd(a, d);
            chk("R10 unmapped reads zero", d, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule